// File: doc/BRIEF.md
# Addressable Bit Latch with Mode-Dependent Clear

This block keeps an array of output bits, eight by default. A single serial data bit is written into one of them, and a binary address chooses which one. Two active-low controls, a write enable and a clear, together pick one of four modes:

- writing one addressed bit while the others keep their values;
- holding every bit;
- acting as a one-of-N demultiplexer, where the addressed bit follows the data and all other bits are zero;
- clearing every bit.

The clear therefore depends on the enable. With the enable released it empties the whole array. With the enable asserted it spares the addressed bit, which keeps following the data input.

The block runs on a system clock. Every control, address and data input is sampled at each rising edge, and the output bits are registered, so any effect of the inputs appears one clock later. The last cycle in which the enable is low decides the value a bit keeps after the enable is released. A synchronous active-high reset, separate from the clear input, zeroes the outputs.

Top module: `addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q` becomes 0 after that edge.
- R2: With `clr_n`=1 and `en_n`=0, the bit of `q` chosen by `addr` takes the value of `din`. Every other bit keeps its value.
- R3: With `clr_n`=1 and `en_n`=1, every bit of `q` keeps its value, whatever `din` and `addr` do.
- R4: With `clr_n`=0 and `en_n`=1, every bit of `q` becomes 0.
- R5: With `clr_n`=0 and `en_n`=0, the addressed bit takes `din` and every other bit becomes 0, so at most one bit of `q` is 1.
- R6: `addr` is read as an unsigned binary number whose most significant bit is `addr[2]`. The value n selects `q[n]`, so 0 selects `q[0]` and 7 selects `q[7]`.
- R7: When `en_n` goes from 0 to 1 with `clr_n`=1, the addressed bit keeps the `din` value sampled in the last cycle with `en_n`=0, and keeps it from then on.
- R8: If `addr` changes while `en_n` stays 0 and `clr_n`=1, only the newly addressed bit follows `din`. The previously addressed bit keeps the last value written to it.
- R9: Inputs sampled at one rising edge change `q` only after that same edge. Before that edge, `q` shows no effect of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit |
| addr | input | 3 | Binary index of the target bit |
| en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Clear, active low; its effect depends on `en_n` |
| q | output | 8 | Registered output bits |

## Verification
The assertions assume that every input is a clean 0 or 1 at each rising edge and that `addr` always selects an existing bit. With the default width, every address value is valid. They place no constraint on when `addr` may change, because the model samples the address at clock edges and has no asynchronous hazard to guard against. The stimulus drives all inputs at the falling clock edge, so their values are settled half a period before they are sampled. Random sequences cover all four control combinations and every address, including address changes while the enable is held low.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    LM_WRITE = 2'd0,
    LM_HOLD  = 2'd1,
    LM_DEMUX = 2'd2,
    LM_CLEAR = 2'd3
  } lmode_t;

  // Control pair to mode
  function automatic lmode_t mode_of(input logic clr_n, input logic en_n);
    case ({clr_n, en_n})
      2'b10:   return LM_WRITE;
      2'b11:   return LM_HOLD;
      2'b00:   return LM_DEMUX;
      default: return LM_CLEAR;
    endcase
  endfunction

  // Next value of one bit given mode, selection, data and current value
  function automatic logic bit_next(input lmode_t m, input logic sel,
                                    input logic d, input logic cur);
    case (m)
      LM_WRITE: return sel ? d : cur;
      LM_DEMUX: return sel ? d : 1'b0;
      LM_HOLD:  return cur;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alatch_ctrl.sv
module alatch_ctrl
  import addr_latch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en_n,
  input  logic   clr_n,
  output lmode_t mode,
  output logic   rise_evt
);

  logic en_prev_n;

  always_ff @(posedge clk) begin
    if (rst) en_prev_n <= 1'b1;
    else     en_prev_n <= en_n;
  end

  assign mode     = mode_of(clr_n, en_n);
  assign rise_evt = en_n & ~en_prev_n;

endmodule

// File: rtl/alatch_decode.sv
module alatch_decode #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  sel
);

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

  always_comb begin
    a_sel_single_r6: assert ($countones(sel) == 1 || $isunknown(addr));
  end

endmodule

// File: rtl/alatch_bank.sv
module alatch_bank
  import addr_latch_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  lmode_t           mode,
  input  logic [NBITS-1:0] sel,
  input  logic             din,
  output logic [NBITS-1:0] q
);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= bit_next(mode, sel[i], din, q[i]);
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> q == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mode == LM_HOLD |=> $stable(q));

  p_clear_all_r4: assert property (@(posedge clk) disable iff (rst)
    mode == LM_CLEAR |=> q == '0);

  p_others_kept_r2: assert property (@(posedge clk) disable iff (rst)
    mode == LM_WRITE |=> (q & ~$past(sel)) == ($past(q) & ~$past(sel)));

  p_demux_one_r5: assert property (@(posedge clk) disable iff (rst)
    mode == LM_DEMUX |=> $countones(q) <= 1);

  p_demux_others_r5: assert property (@(posedge clk) disable iff (rst)
    mode == LM_DEMUX |=> (q & ~$past(sel)) == '0);

endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              clr_n,
  output logic [NBITS-1:0]  q
);

  lmode_t           mode;
  logic             rise_evt;
  logic [NBITS-1:0] sel;

  alatch_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en_n     (en_n),
    .clr_n    (clr_n),
    .mode     (mode),
    .rise_evt (rise_evt)
  );

  alatch_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  alatch_bank #(.NBITS(NBITS)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .sel  (sel),
    .din  (din),
    .q    (q)
  );

  // The addressed bit tracks data while enabled (R2, R5, R6)
  p_follow_r6: assert property (@(posedge clk) disable iff (rst)
    !en_n |=> q[$past(addr)] == $past(din));

  // On enable release, the bit written in the last enabled cycle is intact
  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    rise_evt |-> q[$past(addr)] == $past(din));

endmodule

// File: tb/tb_addr_latch.sv
`timescale 1ns/1ps
module tb_addr_latch;

  logic       clk = 1'b0;
  logic       rst;
  logic       din;
  logic [2:0] addr;
  logic       en_n;
  logic       clr_n;
  logic [7:0] q;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model;

  always #2.5 clk = ~clk;

  addr_latch dut (
    .clk(clk), .rst(rst), .din(din), .addr(addr),
    .en_n(en_n), .clr_n(clr_n), .q(q)
  );

  // Vector fields: {clr_n, en_n, addr[2:0], din}
  localparam logic [5:0] VEC [24] = '{
    6'b10_000_1, 6'b10_011_1, 6'b10_111_1, 6'b11_111_0,
    6'b11_010_1, 6'b10_011_0, 6'b10_101_1, 6'b11_000_0,
    6'b00_100_1, 6'b00_110_0, 6'b00_001_1, 6'b01_001_1,
    6'b10_010_1, 6'b10_110_1, 6'b11_110_0, 6'b00_000_1,
    6'b00_111_1, 6'b10_100_1, 6'b10_100_0, 6'b01_010_1,
    6'b10_101_1, 6'b10_001_1, 6'b11_011_1, 6'b11_000_1
  };

  // Reference behaviour, from the requirement list
  function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic c,
                                          input logic e, input logic [2:0] a,
                                          input logic d);
    logic [7:0] r;
    r = c ? cur : 8'h00;
    if (!e) r[a] = d;
    return r;
  endfunction

  function automatic string tag_of(input logic c, input logic e);
    if (c && !e) return "R2";
    if (c && e)  return "R3";
    if (!c && e) return "R4";
    return "R5";
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    n_tests++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%b expected=%b", tag, q, exp);
    end
  endtask

  // Drive at negedge, sample at the next negedge
  task automatic step(input logic c, input logic e, input logic [2:0] a,
                      input logic d, input string tag);
    clr_n = c; en_n = e; addr = a; din = d;
    model = ref_next(model, c, e, a, d);
    @(negedge clk);
    check(model, tag);
  endtask

  initial begin
    #(5ns * 20000);
    n_fail++;
    $display("FAIL watchdog: q=%b expected=finish", q);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; din = 1'b1; addr = 3'd5; en_n = 1'b0; clr_n = 1'b1;
    model = 8'h00;
    repeat (3) @(negedge clk);
    check(8'h00, "R1");
    rst = 1'b0;
    en_n = 1'b1;

    // Table walk
    for (int i = 0; i < 24; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3:1], VEC[i][0],
           tag_of(VEC[i][5], VEC[i][4]));
    end

    // R6: each address in demux mode lights exactly bit n
    for (int n = 0; n < 8; n++) begin
      step(1'b0, 1'b0, 3'(n), 1'b1, "R6");
      check(8'h01 << n, "R6");
    end

    // R7: value of last enabled cycle stays after release
    step(1'b0, 1'b1, 3'd0, 1'b0, "R4");
    step(1'b1, 1'b0, 3'd4, 1'b0, "R2");
    step(1'b1, 1'b0, 3'd4, 1'b1, "R2");
    step(1'b1, 1'b1, 3'd1, 1'b0, "R7");
    check(8'h10, "R7");
    step(1'b1, 1'b1, 3'd4, 1'b0, "R7");
    check(8'h10, "R7");

    // R8: address moves while enabled
    step(1'b1, 1'b0, 3'd2, 1'b1, "R8");
    step(1'b1, 1'b0, 3'd3, 1'b1, "R8");
    step(1'b1, 1'b0, 3'd3, 1'b0, "R8");
    check(8'h14, "R8");

    // R9: no effect before the edge, effect after it
    clr_n = 1'b0; en_n = 1'b1; addr = 3'd0; din = 1'b0;
    #1;
    check(8'h14, "R9");
    model = 8'h00;
    @(negedge clk);
    check(8'h00, "R9");

    // R3: hold while data and address wander
    step(1'b1, 1'b0, 3'd6, 1'b1, "R2");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 3'(i), i[0], "R3");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(r[5], r[4], r[3:1], r[0], tag_of(r[5], r[4]));
    end

    // R1: reset mid-run
    step(1'b1, 1'b0, 3'd7, 1'b1, "R2");
    rst = 1'b1;
    @(negedge clk);
    check(8'h00, "R1");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule